// File: doc/BRIEF.md
# Step Attenuator Control Register

This block is the digital control front end of a 7-bit step attenuator. It accepts an attenuation setting either over a three-wire serial port (data, shift clock, latch enable) or over seven parallel control inputs. A mode-select input chooses between the two. It produces one registered 7-bit code that drives the analog switch core. The code counts attenuation in quarter-dB steps: bit 0 weighs 0.25 dB and bit 6 weighs 16 dB. All zeros selects the minimum (reference) state, and all ones selects 31.75 dB.

The serial port, the latch enable and the parallel inputs come from outside the system clock domain. They are brought in through a two-flop synchroniser and then edge-detected on the system clock. There are three ways to program the block. In serial mode an 8-bit word is shifted in and then latched. In latched-parallel mode the parallel inputs are captured on a latch pulse. In direct-parallel mode the latch enable is held high and the code follows the parallel inputs. Reset forces the maximum code. A serial word whose top bit is set is refused: the code is left unchanged and an error flag is raised.

Top module: `step_atten_ctrl`

## Requirements
- R1: During and after a synchronous reset (active-low), the code output is all ones (127) and the word error flag is 0. Both keep these values until a new word is accepted.
- R2: On every rising shift-clock edge seen while latch enable is low, the 8-bit shift register takes the serial data bit in at its top and moves towards bit 0. The first bit sent therefore ends in bit 0. Shifting does not alter the code output.
- R3: With select high (serial), a rising latch-enable edge copies shift-register bits 6:0 to the code output. The code keeps that value after latch enable falls.
- R4: If a serial word with bit 7 set is latched, the code output keeps its old value and the error flag goes to 1. The flag returns to 0 on the next serial latch of a word with bit 7 clear.
- R5: With select low (parallel) and latch enable high, the code output follows the parallel inputs (direct mode).
- R6: With select low, a latch-enable pulse captures the parallel inputs. While latch enable stays low, changes on the parallel inputs do not reach the code output.
- R7: With select high, the parallel inputs have no effect on the code output, whether or not latch enable is pulsed.
- R8: The code is the attenuation in quarter-dB units: 12.5 dB is code 50 (0110010), 31.75 dB is 127 and 0 dB is 0.
- R9: A change on any input reaches the code output on the third rising clock edge after it is applied. The first two edges are synchroniser stages and the third is the output register.
- R10: If a rising shift-clock edge and a rising latch-enable edge reach the synchronised domain in the same cycle, no shift takes place. The latch copies the shift register as it was before that edge.
- R11: Rising shift-clock edges seen while latch enable is high leave the shift register unchanged. A second latch pulse with no shifting in between reproduces the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel_i | input | 1 | Interface select: 1 serial, 0 parallel |
| ser_din_i | input | 1 | Serial data, least significant bit first |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| latch_en_i | input | 1 | Latch enable (asynchronous) |
| par_code_i | input | 7 | Parallel attenuation code |
| atten_code_o | output | 7 | Registered attenuation code to switch core |
| word_err_o | output | 1 | Set when a serial word with bit 7 set was refused |

## Verification
A shift and a latch can fall in the same synchronised cycle. The shift register moves on a shift-clock rise only while latch enable is low, while the latch fires on the rise of latch enable. The bench provokes the collision by raising the shift clock, a new data bit and latch enable on the same clock. It then checks that the code equals the word shifted in before that edge. A later latch pulse, with no shifting in between, must give the same code and no error, which shows that the colliding edge did not shift the register. A behavioural reference model tracks the synchroniser delay with a history queue and is compared with the outputs on every clock.

// File: rtl/atten_pkg.sv
// Package: shared constants and the mode type for the step attenuator control.
// Assumes a 7-bit code fed from an 8-bit serial word.
package atten_pkg;
    localparam int unsigned CODE_BITS = 7;
    localparam int unsigned WORD_BITS = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    // Decoded update source for the output code register
    typedef enum logic [1:0] {
        MODE_SERIAL   = 2'd0,
        MODE_PAR_LOAD = 2'd1,
        MODE_PAR_HOLD = 2'd2
    } upd_mode_e;
endpackage

// File: rtl/atten_sync.sv
// Module: multi-bit flop-chain synchroniser.
// Assumes each bit is independent, or that bits are quasi-static against one another.
// Reset clears all stages synchronously.
module atten_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Move the inputs one stage down the chain each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/atten_shifter.sv
// Module: serial shift register for the attenuation word.
// Inputs are already synchronised. A rising edge of the shift clock shifts one
// bit in at the top while latch enable is low, so the first bit sent ends in bit 0.
module atten_shifter #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi_i,
    input  logic              sclk_i,
    input  logic              le_i,
    output logic [WORD_W-1:0] word_o
);
    logic              sclk_q;
    logic              shift_en;
    logic [WORD_W-1:0] word_q;

    // Keep last shift-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign shift_en = sclk_i & ~sclk_q & ~le_i;

    // Shift the word on an accepted shift-clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {sdi_i, word_q[WORD_W-1:1]};
    end

    assign word_o = word_q;

    assert_hold_while_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(le_i) |-> $stable(word_q));

    assert_lsb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> (word_q[WORD_W-2:0] == $past(word_q[WORD_W-1:1])));
endmodule

// File: rtl/atten_code_reg.sv
// Module: output code register and mode decode.
// Serial mode loads the low bits of the shifted word on a latch-enable rise,
// unless the bits above the code are non-zero. Parallel mode loads the parallel
// inputs for as long as latch enable is high. Reset forces full attenuation.
module atten_code_reg
    import atten_pkg::*;
#(
    parameter int unsigned CODE_W = 7,
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              le_i,
    input  logic [CODE_W-1:0] par_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o,
    output logic              err_o
);
    localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

    logic              le_q;
    logic              le_rise;
    logic              word_ok;
    upd_mode_e         mode;
    logic [CODE_W-1:0] code_q;
    logic              err_q;

    // Keep last latch-enable level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= le_i;
    end

    assign le_rise = le_i & ~le_q;
    assign word_ok = ~|word_i[WORD_W-1:CODE_W];

    // Decode which source, if any, updates the code this cycle
    always_comb begin
        if (sel_i)     mode = MODE_SERIAL;
        else if (le_i) mode = MODE_PAR_LOAD;
        else           mode = MODE_PAR_HOLD;
    end

    // Update the code and the error flag from the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= FULL_CODE;
            err_q  <= 1'b0;
        end else begin
            case (mode)
                MODE_SERIAL: begin
                    if (le_rise) begin
                        if (word_ok) begin
                            code_q <= word_i[CODE_W-1:0];
                            err_q  <= 1'b0;
                        end else begin
                            err_q  <= 1'b1;
                        end
                    end
                end
                MODE_PAR_LOAD: code_q <= par_i;
                default:       code_q <= code_q;
            endcase
        end
    end

    assign code_o = code_q;
    assign err_o  = err_q;

    assert_update_needs_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> $past(le_i));

    assert_bad_word_keeps_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $stable(code_q));

    assert_err_serial_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_q) |-> $past(sel_i));

    assert_serial_ignores_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_i) && !$stable(code_q)) |-> (code_q == $past(word_i[CODE_W-1:0])));
endmodule

// File: rtl/step_atten_ctrl.sv
// Module: top of the step attenuator control register.
// All asynchronous control inputs go through one synchroniser bundle, so that
// serial data, shift clock, latch enable, select and parallel code stay aligned.
module step_atten_ctrl
    import atten_pkg::*;
#(
    parameter int unsigned CODE_W      = CODE_BITS,
    parameter int unsigned WORD_W      = WORD_BITS,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_i,
    input  logic              ser_din_i,
    input  logic              ser_clk_i,
    input  logic              latch_en_i,
    input  logic [CODE_W-1:0] par_code_i,
    output logic [CODE_W-1:0] atten_code_o,
    output logic              word_err_o
);
    localparam int unsigned BUNDLE_W = CODE_W + 4;

    logic [BUNDLE_W-1:0] raw_bus;
    logic [BUNDLE_W-1:0] sync_bus;
    logic                sel_s;
    logic                le_s;
    logic                sclk_s;
    logic                sdi_s;
    logic [CODE_W-1:0]   par_s;
    logic [WORD_W-1:0]   shift_word;

    assign raw_bus = {ser_sel_i, latch_en_i, ser_clk_i, ser_din_i, par_code_i};

    atten_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (sync_bus)
    );

    assign {sel_s, le_s, sclk_s, sdi_s, par_s} = sync_bus;

    atten_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdi_i  (sdi_s),
        .sclk_i (sclk_s),
        .le_i   (le_s),
        .word_o (shift_word)
    );

    atten_code_reg #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel_s),
        .le_i   (le_s),
        .par_i  (par_s),
        .word_i (shift_word),
        .code_o (atten_code_o),
        .err_o  (word_err_o)
    );
endmodule

// File: tb/step_atten_ctrl_test.sv
// Bench: behavioural reference model with an input history queue, compared
// every clock, plus directed checks with literal expected values.
module step_atten_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_r = 1'b1;
    logic       sdi_r = 1'b0;
    logic       sclk_r = 1'b0;
    logic       le_r = 1'b0;
    logic [6:0] par_r = 7'd0;
    logic [6:0] code_w;
    logic       err_w;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    started = 1'b0;
    string cur_req = "R1";

    logic [10:0] hist[$];
    logic [10:0] d_v;
    logic [10:0] p_v;
    logic [7:0]  m_sreg;
    logic [7:0]  old_sreg;
    logic [6:0]  m_code;
    logic        m_err;

    always #4 clk = ~clk;

    step_atten_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_sel_i    (sel_r),
        .ser_din_i    (sdi_r),
        .ser_clk_i    (sclk_r),
        .latch_en_i   (le_r),
        .par_code_i   (par_r),
        .atten_code_o (code_w),
        .word_err_o   (err_w)
    );

    // Reference model: inputs seen two edges late, previous sample for edges
    always @(posedge clk) begin
        if (hist.size() < 4) hist = '{11'd0, 11'd0, 11'd0, 11'd0};
        if (!rst_n) begin
            hist.push_back(11'd0);
            m_code = 7'h7F;
            m_err  = 1'b0;
            m_sreg = 8'd0;
        end else begin
            hist.push_back({sel_r, le_r, sclk_r, sdi_r, par_r});
            d_v = hist[hist.size()-3];
            p_v = hist[hist.size()-4];
            old_sreg = m_sreg;
            if (d_v[8] && !p_v[8] && !d_v[9]) m_sreg = {d_v[7], m_sreg[7:1]};
            if (d_v[10]) begin
                if (d_v[9] && !p_v[9]) begin
                    if (old_sreg[7]) m_err = 1'b1;
                    else begin
                        m_code = old_sreg[6:0];
                        m_err  = 1'b0;
                    end
                end
            end else if (d_v[9]) begin
                m_code = d_v[6:0];
            end
        end
        if (hist.size() > 8) void'(hist.pop_front());
        started = 1'b1;
    end

    // Compare design with model every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (code_w !== m_code || err_w !== m_err) begin
                errors++;
                $display("FAIL %s model: code=%0d err=%0b expected code=%0d err=%0b",
                         cur_req, code_w, err_w, m_code, m_err);
            end
        end
    end

    task automatic chk(input string req, input logic [6:0] exp_code, input logic exp_err);
        checks++;
        if (code_w !== exp_code || err_w !== exp_err) begin
            errors++;
            $display("FAIL %s: code=%0d err=%0b expected code=%0d err=%0b",
                     req, code_w, err_w, exp_code, exp_err);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_shift(input logic [7:0] w);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sdi_r  = w[i];
            sclk_r = 1'b0;
            settle(2);
            sclk_r = 1'b1;
            settle(1);
        end
        @(negedge clk);
        sclk_r = 1'b0;
        settle(3);
    endtask

    task automatic latch_pulse;
        @(negedge clk);
        le_r = 1'b1;
        settle(2);
        le_r = 1'b0;
        settle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        settle(5);
        chk("R1", 7'h7F, 1'b0);
        rst_n = 1'b1;
        settle(5);
        chk("R1", 7'h7F, 1'b0);

        cur_req = "R2";
        ser_shift(8'd50);
        chk("R2", 7'h7F, 1'b0);
        cur_req = "R8";
        latch_pulse();
        chk("R8", 7'd50, 1'b0);
        settle(4);
        chk("R3", 7'd50, 1'b0);

        cur_req = "R4";
        ser_shift(8'h85);
        latch_pulse();
        chk("R4", 7'd50, 1'b1);
        ser_shift(8'h0A);
        latch_pulse();
        chk("R4", 7'd10, 1'b0);

        cur_req = "R7";
        @(negedge clk);
        par_r = 7'h55;
        settle(5);
        chk("R7", 7'd10, 1'b0);
        latch_pulse();
        chk("R7", 7'd10, 1'b0);
        par_r = 7'd0;

        cur_req = "R10";
        ser_shift(8'h21);
        settle(2);
        sdi_r  = 1'b1;
        sclk_r = 1'b1;
        le_r   = 1'b1;
        settle(2);
        le_r   = 1'b0;
        sclk_r = 1'b0;
        settle(4);
        chk("R10", 7'd33, 1'b0);
        cur_req = "R11";
        latch_pulse();
        chk("R11", 7'd33, 1'b0);

        cur_req = "R5";
        @(negedge clk);
        sel_r = 1'b0;
        le_r  = 1'b1;
        par_r = 7'd0;
        settle(4);
        chk("R5", 7'd0, 1'b0);
        par_r = 7'h7F;
        settle(4);
        chk("R5", 7'h7F, 1'b0);
        par_r = 7'h2A;
        settle(4);
        chk("R5", 7'h2A, 1'b0);

        cur_req = "R9";
        par_r = 7'h15;
        settle(2);
        chk("R9", 7'h2A, 1'b0);
        settle(1);
        chk("R9", 7'h15, 1'b0);

        cur_req = "R6";
        settle(2);
        le_r = 1'b0;
        settle(4);
        par_r = 7'h11;
        settle(4);
        chk("R6", 7'h15, 1'b0);
        latch_pulse();
        chk("R6", 7'h11, 1'b0);
        par_r = 7'h70;
        settle(4);
        chk("R6", 7'h11, 1'b0);

        cur_req = "R8";
        sel_r = 1'b1;
        par_r = 7'd0;
        settle(4);
        ser_shift(8'h7F);
        latch_pulse();
        chk("R8", 7'h7F, 1'b0);
        ser_shift(8'h00);
        latch_pulse();
        chk("R8", 7'd0, 1'b0);

        cur_req = "R7";
        par_r = 7'h55;
        latch_pulse();
        chk("R7", 7'd0, 1'b0);

        cur_req = "R1";
        rst_n = 1'b0;
        settle(2);
        chk("R1", 7'h7F, 1'b0);
        rst_n = 1'b1;
        settle(5);
        chk("R1", 7'h7F, 1'b0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule